// File: doc/BRIEF.md
# Saturating Audio Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point audio signal processor. Each clock it computes one result, taken in a fixed order. First an upper adder combines the current accumulator and an incoming operand. A multiplier then scales that sum by a short coefficient. Last, a lower adder adds a second operand. When the operation asks for a write, the result goes into the accumulator and the old accumulator value moves into a previous-accumulator register.

Data words are 24-bit signed fractions and keep their full width through the multiply. Coefficients are far narrower. A per-operation field picks the coefficient from one of four places: an immediate value carried by the instruction, an oscillator input, the top 15 bits of a register word, or a fixed unity value. The upper adder can pass the accumulator on its own, so the accumulator can be multiplied by a register value.

Both adders clamp to the 24-bit limits instead of wrapping. The product is brought back to the data scale by dropping its low bits, which rounds toward minus infinity.

Top module: `audio_mac_datapath`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `acc_q` and `pacc_q` read zero until the first write.
- R2: The upper sum is built from the accumulator (when `op_code[0]` is 1) and `opnd_a` (when `op_code[1]` is 1). The sum is clamped to 0x7FFFFF or 0x800000 instead of wrapping.
- R3: The upper sum is multiplied at full 24-bit width by a coefficient with 14 fraction bits. The product is shifted right by 14 with low bits dropped, so a negative half-LSB result becomes -1 (0xFFFFFF) and a positive one becomes 0.
- R4: `op_code[3:2]` picks the coefficient: 00 immediate, 01 `osc_coef` (15-bit signed), 10 `reg_word[23:9]` as a 15-bit signed value with `reg_word[8:0]` discarded, 11 unity (+1.0).
- R5: With `op_code[4]` = 0, the immediate is `imm_coef[14:0]` signed, covering -1.0 to just under +1.0, and `imm_coef[15]` is ignored. With `op_code[4]` = 1, all 16 bits of `imm_coef` form a signed value with one integer bit, covering -2.0 to just under +2.0.
- R6: The lower adder adds `opnd_b` to the scaled product and clamps the result to 0x7FFFFF or 0x800000.
- R7: When `op_code[5]` is 1, the next edge loads the result into `acc_q` and loads the old `acc_q` into `pacc_q`. When it is 0, both registers hold.
- R8: With only `op_code[0]` set in the upper adder, the accumulator alone reaches the multiplier, so the accumulator is multiplied by the selected coefficient.
- R9: A register-sourced coefficient and a 15-bit immediate holding the same top bits give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 6 | Bit 0 accumulator into upper adder, bit 1 operand A into upper adder, bits 3:2 coefficient source, bit 4 immediate format, bit 5 write |
| opnd_a | input | 24 | Upper adder operand, signed fraction |
| opnd_b | input | 24 | Lower adder operand, signed fraction |
| imm_coef | input | 16 | Immediate coefficient from the instruction |
| osc_coef | input | 15 | Oscillator coefficient, signed, 14 fraction bits |
| reg_word | input | 24 | Register word whose top 15 bits can serve as coefficient |
| acc_q | output | 24 | Accumulator |
| pacc_q | output | 24 | Previous accumulator |

## Verification
A scoreboard predicts each result from the requirements and compares it one cycle later. Loads through the unity coefficient isolate the upper adder and the write path from the multiplier. Sums of same-signed large values in both adders separate saturation from wrap-around. Halving +1 and -1 distinguishes dropping low bits from rounding. The same value is offered as a register word with junk low bits and as an immediate with and without its top bit set, which shows that discarded bits have no effect and that the two formats are scaled differently. A run of pseudo-random operations with mixed writes and holds covers the remaining combinations of sources and operand signs.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Field positions inside the operation code
    localparam int OP_W       = 6;
    localparam int OPB_ACC    = 0;
    localparam int OPB_OPA    = 1;
    localparam int OPB_SRC_LO = 2;
    localparam int OPB_FMT    = 4;
    localparam int OPB_WR     = 5;

    // Coefficient source select
    typedef enum logic [1:0] {
        CSRC_IMM   = 2'b00,
        CSRC_OSC   = 2'b01,
        CSRC_REG   = 2'b10,
        CSRC_UNITY = 2'b11
    } coef_src_e;

endpackage

// File: rtl/mac_sat_add.sv
// Signed adder with sign extension to an internal width and clamping
// of the result to an OUT_W-bit signed range.
module mac_sat_add #(
    parameter int A_W   = 24,
    parameter int B_W   = 24,
    parameter int OUT_W = 24
) (
    input  logic signed [A_W-1:0]   a_in,
    input  logic signed [B_W-1:0]   b_in,
    output logic signed [OUT_W-1:0] sum_out
);

    localparam int MAX_IN = (A_W > B_W) ? A_W : B_W;
    localparam int SUM_W  = ((MAX_IN > OUT_W) ? MAX_IN : OUT_W) + 1;

    localparam logic signed [SUM_W-1:0] POS_LIM =
        {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] NEG_LIM =
        {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [SUM_W-1:0] a_ext;
    logic signed [SUM_W-1:0] b_ext;
    logic signed [SUM_W-1:0] raw_sum;

    always_comb begin
        a_ext   = {{(SUM_W-A_W){a_in[A_W-1]}}, a_in};
        b_ext   = {{(SUM_W-B_W){b_in[B_W-1]}}, b_in};
        raw_sum = a_ext + b_ext;
        if (raw_sum > POS_LIM) begin
            sum_out = POS_LIM[OUT_W-1:0];
        end else if (raw_sum < NEG_LIM) begin
            sum_out = NEG_LIM[OUT_W-1:0];
        end else begin
            sum_out = raw_sum[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/mac_coef_select.sv
// Picks the multiplier coefficient and presents it as a signed value
// with one integer bit and COEF_W-1 fraction bits.
module mac_coef_select
    import mac_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int COEF_W = 15
) (
    input  coef_src_e                src_sel,
    input  logic                     wide_fmt,
    input  logic [COEF_W:0]          imm_coef,
    input  logic [COEF_W-1:0]        osc_coef,
    input  logic [DATA_W-1:0]        reg_word,
    output logic signed [COEF_W:0]   coef_out
);

    localparam int CI_W     = COEF_W + 1;
    localparam int FRAC_W   = COEF_W - 1;
    localparam int REG_DROP = DATA_W - COEF_W;

    localparam logic signed [CI_W-1:0] UNITY = CI_W'(1) << FRAC_W;

    logic [COEF_W-1:0] reg_top;
    logic [COEF_W-1:0] imm_narrow;

    always_comb begin
        reg_top    = COEF_W'(reg_word >> REG_DROP);
        imm_narrow = COEF_W'(imm_coef);
        unique case (src_sel)
            CSRC_IMM: begin
                if (wide_fmt) begin
                    coef_out = imm_coef;
                end else begin
                    coef_out = {imm_narrow[COEF_W-1], imm_narrow};
                end
            end
            CSRC_OSC:   coef_out = {osc_coef[COEF_W-1], osc_coef};
            CSRC_REG:   coef_out = {reg_top[COEF_W-1], reg_top};
            CSRC_UNITY: coef_out = UNITY;
            default:    coef_out = '0;
        endcase
    end

endmodule

// File: rtl/mac_scale_mult.sv
// Full-width product of a data word and a coefficient, returned to the
// data scale by dropping the fraction bits of the coefficient.
module mac_scale_mult #(
    parameter int DATA_W = 24,
    parameter int COEF_W = 15
) (
    input  logic signed [DATA_W-1:0] data_in,
    input  logic signed [COEF_W:0]   coef_in,
    output logic signed [DATA_W+1:0] scaled_out
);

    localparam int FRAC_W = COEF_W - 1;
    localparam int PROD_W = DATA_W + COEF_W + 1;
    localparam int SCL_W  = DATA_W + 2;

    logic signed [PROD_W-1:0] prod_full;
    logic signed [PROD_W-1:0] prod_shift;

    always_comb begin
        prod_full  = PROD_W'(data_in) * PROD_W'(coef_in);
        prod_shift = prod_full >>> FRAC_W;
        scaled_out = SCL_W'(prod_shift);
    end

endmodule

// File: rtl/audio_mac_datapath.sv
module audio_mac_datapath
    import mac_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int COEF_W = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      op_code,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    input  logic [COEF_W:0]      imm_coef,
    input  logic [COEF_W-1:0]    osc_coef,
    input  logic [DATA_W-1:0]    reg_word,
    output logic [DATA_W-1:0]    acc_q,
    output logic [DATA_W-1:0]    pacc_q
);

    localparam int CI_W  = COEF_W + 1;
    localparam int SCL_W = DATA_W + 2;

    coef_src_e                 src_sel;
    logic signed [DATA_W-1:0]  up_lhs;
    logic signed [DATA_W-1:0]  up_rhs;
    logic signed [DATA_W-1:0]  up_sum;
    logic signed [CI_W-1:0]    coef_w;
    logic signed [SCL_W-1:0]   scaled;
    logic signed [DATA_W-1:0]  result;

    // Operand gating for the upper adder
    always_comb begin
        src_sel = coef_src_e'(op_code[OPB_SRC_LO +: 2]);
        up_lhs  = op_code[OPB_ACC] ? acc_q  : '0;
        up_rhs  = op_code[OPB_OPA] ? opnd_a : '0;
    end

    mac_sat_add #(
        .A_W   (DATA_W),
        .B_W   (DATA_W),
        .OUT_W (DATA_W)
    ) u_upper_add (
        .a_in    (up_lhs),
        .b_in    (up_rhs),
        .sum_out (up_sum)
    );

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[OPB_ACC] && op_code[OPB_OPA] && !acc_q[DATA_W-1] && !opnd_a[DATA_W-1])
        |-> !up_sum[DATA_W-1]);

    mac_coef_select #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W)
    ) u_coef_sel (
        .src_sel  (src_sel),
        .wide_fmt (op_code[OPB_FMT]),
        .imm_coef (imm_coef),
        .osc_coef (osc_coef),
        .reg_word (reg_word),
        .coef_out (coef_w)
    );

    // R4
    reg_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == CSRC_REG) |-> (coef_w[COEF_W-1:0] == reg_word[DATA_W-1 -: COEF_W]));

    mac_scale_mult #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W)
    ) u_mult (
        .data_in    (up_sum),
        .coef_in    (coef_w),
        .scaled_out (scaled)
    );

    mac_sat_add #(
        .A_W   (SCL_W),
        .B_W   (DATA_W),
        .OUT_W (DATA_W)
    ) u_lower_add (
        .a_in    (scaled),
        .b_in    (opnd_b),
        .sum_out (result)
    );

    // Accumulator pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            pacc_q <= '0;
        end else if (op_code[OPB_WR]) begin
            acc_q  <= result;
            pacc_q <= acc_q;
        end
    end

    // R7
    pacc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_code[OPB_WR] |=> (pacc_q == $past(acc_q)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_code[OPB_WR] |=> ($stable(acc_q) && $stable(pacc_q)));

    // R6
    zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[OPB_WR] && coef_w == '0) |=> (acc_q == $past(opnd_b)));

endmodule

// File: tb/tb_audio_mac_datapath.sv
module tb_audio_mac_datapath;

    localparam int DW = 24;
    localparam int CW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    op_code = '0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic [CW:0]   imm_coef = '0;
    logic [CW-1:0] osc_coef = '0;
    logic [DW-1:0] reg_word = '0;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] pacc_q;

    always #2 clk = ~clk;

    audio_mac_datapath dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm_coef (imm_coef),
        .osc_coef (osc_coef),
        .reg_word (reg_word),
        .acc_q    (acc_q),
        .pacc_q   (pacc_q)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [DW-1:0] q_acc[$];
    logic [DW-1:0] q_pacc[$];
    string         q_tag[$];
    logic [DW-1:0] m_acc = '0;
    logic [DW-1:0] m_pacc = '0;

    function automatic longint clampv(input longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    // Prediction straight from R2..R6
    function automatic logic [DW-1:0] predict(
        input logic [DW-1:0] acc, input logic [5:0] op,
        input logic [DW-1:0] a, input logic [DW-1:0] b,
        input logic [CW:0] imm, input logic [CW-1:0] osc,
        input logic [DW-1:0] rw);
        longint up, c, p, lo;
        up = 0;
        if (op[0]) up = up + longint'($signed(acc));
        if (op[1]) up = up + longint'($signed(a));
        up = clampv(up);
        case (op[3:2])
            2'b00:   c = op[4] ? longint'($signed(imm)) : longint'($signed(imm[14:0]));
            2'b01:   c = longint'($signed(osc));
            2'b10:   c = longint'($signed(rw[23:9]));
            default: c = 64'sd16384;
        endcase
        p  = (up * c) >>> 14;
        lo = clampv(p + longint'($signed(b)));
        return lo[DW-1:0];
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] ga, input logic [DW-1:0] ea,
                         input logic [DW-1:0] gp, input logic [DW-1:0] ep);
        n_tests++;
        if (ga !== ea || gp !== ep) begin
            n_fail++;
            $display("FAIL %s acc=%h expected %h pacc=%h expected %h", tag, ga, ea, gp, ep);
        end
    endtask

    // Driver: applies one operation and pushes its expected outcome
    task automatic drive(input logic [5:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [CW:0] imm, input logic [CW-1:0] osc,
                         input logic [DW-1:0] rw, input string tag);
        logic [DW-1:0] res;
        @(posedge clk);
        #1;
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        imm_coef = imm;
        osc_coef = osc;
        reg_word = rw;
        res = predict(m_acc, op, a, b, imm, osc, rw);
        if (op[5]) begin
            m_pacc = m_acc;
            m_acc  = res;
        end
        q_acc.push_back(m_acc);
        q_pacc.push_back(m_pacc);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops the item captured at this edge, compares mid-cycle
    initial begin
        logic [DW-1:0] ea, ep;
        string tg;
        forever begin
            @(posedge clk);
            if (q_acc.size() > 0) begin
                ea = q_acc.pop_front();
                ep = q_pacc.pop_front();
                tg = q_tag.pop_front();
                @(negedge clk);
                check(tg, acc_q, ea, pacc_q, ep);
            end
        end
    end

    localparam logic [5:0] OP_LOAD   = 6'b101110;
    localparam logic [5:0] OP_ACCADD = 6'b101111;
    localparam logic [5:0] OP_ACCUNI = 6'b101101;
    localparam logic [5:0] OP_ACCIMM = 6'b100001;
    localparam logic [5:0] OP_ACCIMW = 6'b110001;
    localparam logic [5:0] OP_ACCOSC = 6'b100101;
    localparam logic [5:0] OP_OPAREG = 6'b101010;
    localparam logic [5:0] OP_OPAIMM = 6'b100010;
    localparam logic [5:0] OP_HOLD   = 6'b001111;

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2468;
        #1;
        @(negedge clk);
        // R1: reset state while held
        check("R1 in reset", acc_q, '0, pacc_q, '0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", acc_q, '0, pacc_q, '0);

        drive(OP_LOAD,   24'h123456, 24'h0, 16'h0, 15'h0, 24'h0, "R7 load via unity");
        drive(OP_LOAD,   24'h700000, 24'h0, 16'h0, 15'h0, 24'h0, "R4 unity load");
        drive(OP_ACCADD, 24'h200000, 24'h0, 16'h0, 15'h0, 24'h0, "R2 upper positive clamp");
        drive(OP_LOAD,   24'h900000, 24'h0, 16'h0, 15'h0, 24'h0, "R2 negative load");
        drive(OP_ACCADD, 24'hA00000, 24'h0, 16'h0, 15'h0, 24'h0, "R2 upper negative clamp");
        drive(OP_LOAD,   24'h300000, 24'h0, 16'h0, 15'h0, 24'h0, "R8 preload");
        drive(OP_ACCIMM, 24'h7FFFFF, 24'h0, 16'h2000, 15'h0, 24'h0, "R8 acc times half");
        drive(OP_ACCIMM, 24'h0, 24'h0, 16'hA000, 15'h0, 24'h0, "R5 narrow format ignores bit 15");
        drive(OP_ACCIMW, 24'h0, 24'h0, 16'h6000, 15'h0, 24'h0, "R5 wide format 1.5");
        drive(OP_ACCOSC, 24'h0, 24'h0, 16'h0, 15'h6000, 24'h0, "R4 oscillator coefficient");
        drive(OP_OPAREG, 24'h400000, 24'h0, 16'h0, 15'h0, 24'h2001FF, "R9 register top bits");
        drive(OP_OPAIMM, 24'h400000, 24'h0, 16'h1000, 15'h0, 24'h0, "R9 immediate equivalent");
        drive(OP_LOAD,   24'hFFFFFF, 24'h0, 16'h0, 15'h0, 24'h0, "R3 load -1");
        drive(OP_ACCIMM, 24'h0, 24'h0, 16'h2000, 15'h0, 24'h0, "R3 floor of -0.5 LSB");
        drive(OP_LOAD,   24'h000001, 24'h0, 16'h0, 15'h0, 24'h0, "R3 load +1");
        drive(OP_ACCIMM, 24'h0, 24'h0, 16'h2000, 15'h0, 24'h0, "R3 floor of +0.5 LSB");
        drive(OP_LOAD,   24'h7FF000, 24'h0, 16'h0, 15'h0, 24'h0, "R6 preload");
        drive(OP_ACCUNI, 24'h0, 24'h100000, 16'h0, 15'h0, 24'h0, "R6 lower positive clamp");
        drive(OP_LOAD,   24'h810000, 24'h0, 16'h0, 15'h0, 24'h0, "R6 negative preload");
        drive(OP_ACCUNI, 24'h0, 24'hC00000, 16'h0, 15'h0, 24'h0, "R6 lower negative clamp");
        drive(OP_HOLD,   24'h111111, 24'h222222, 16'h3333, 15'h4444, 24'h555555, "R7 hold without write");
        drive(6'b100000, 24'h0, 24'h0ABCDE, 16'h0, 15'h0, 24'h0, "R6 zero coefficient passes operand B");

        for (int i = 0; i < 60; i++) begin
            logic [5:0] rop;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rop = lfsr[5:0];
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            drive(rop, lfsr[23:0], {lfsr[31:24], lfsr[15:0]}, lfsr[27:12], lfsr[14:0],
                  {lfsr[7:0], lfsr[31:16]}, "R2 R4 R7 mixed pattern");
        end

        while (q_acc.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #80000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired, actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule